// File: doc/BRIEF.md
# Parallel-Port Host Cycle Controller

This block is the host end of an 8-bit enhanced parallel port link. Local logic hands it one command at a time: write an address byte, write a data byte, or read a data byte. The block then runs one complete strobed bus cycle toward the peripheral and reports the result. The peripheral side has two active-low strobes, one for addresses and one for data, and a direction line. It also has an 8-bit bus, split into a driven value, an output enable and a sampled input, and a wait input that the peripheral uses to pace each cycle.

Each cycle follows the full wait handshake. The block sets the direction line and the bus, then pulls the chosen strobe low. It holds the strobe low for a minimum width, and until the peripheral raises wait. It then releases the strobe and waits for wait to fall again. A guard gap must elapse before the next command is taken. Both waiting phases have their own timeout. If a phase times out, the cycle is abandoned and a timeout pulse is raised instead of a done pulse. All time limits are given in nanoseconds and turned into clock counts from a clock-period parameter.

Commands enter on a valid/ready handshake. `cmd_ready` is the only back-pressure. A command held on `cmd_valid` while ready is low waits, and it is taken on the first clock edge where both are high. The result side has no back-pressure: `done` and `timeout` are single-cycle pulses that the consumer must catch.

Top module: `epp_host_master`

## Requirements
- R1: While `rst_n` is low, and right after reset, both strobes are high, `epp_dir` is high, `bus_oe` is low, and `done` and `timeout` are low.
- R2: `cmd_ready` is high only when no cycle is in progress and the synchronised wait is low. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. No strobe moves while `cmd_ready` is low and no cycle was taken.
- R3: `cmd_kind` 2'b00 is an address write. `epp_astb_n` goes low and `epp_dstb_n` stays high. Throughout the strobe, `epp_dir` is low, `bus_oe` is high and `bus_out` holds `cmd_wdata`.
- R4: `cmd_kind` 2'b01 is a data write. It behaves like R3, but uses `epp_dstb_n` and leaves `epp_astb_n` high.
- R5: `cmd_kind` 2'b1x is a data read. `epp_dstb_n` goes low with `epp_dir` high and `bus_oe` low. With the `done` pulse, `done_rdata` carries the `bus_in` value from the first clock in which the synchronised wait was high.
- R6: A strobe stays low for at least ceil(STROBE_MIN_NS/CLK_PERIOD_NS) cycles. Outside a timeout, it is not released before wait has been seen high.
- R7: After the strobe is released, `done` is raised only once wait has fallen. No new strobe falls until at least ceil(SETUP_GAP_NS/CLK_PERIOD_NS) cycles after wait fell.
- R8: If wait stays low for ceil(TIMEOUT_NS/CLK_PERIOD_NS) cycles after the strobe falls, the cycle ends with a `timeout` pulse and no `done`. The strobe is released, `epp_dir` goes high and `bus_oe` goes low in that same cycle.
- R9: If wait stays high for that many cycles after the strobe rises, the cycle likewise ends with a `timeout` pulse and the outputs idle as in R8. `cmd_ready` then stays low until wait falls.
- R10: `done` and `timeout` are each one cycle wide and are never high together.
- R11: While a strobe is low, `epp_dir`, `bus_oe` and `bus_out` do not change, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 2 | 00 address write, 01 data write, 1x data read |
| cmd_wdata | input | 8 | Byte to write |
| done | output | 1 | Cycle finished, one-cycle pulse |
| done_rdata | output | 8 | Read byte, valid with `done` for reads |
| timeout | output | 1 | Cycle abandoned, one-cycle pulse |
| epp_astb_n | output | 1 | Address strobe, active low |
| epp_dstb_n | output | 1 | Data strobe, active low |
| epp_dir | output | 1 | 1 read (peripheral to host), 0 write |
| bus_out | output | 8 | Value driven on the bus |
| bus_oe | output | 1 | Bus driver enable |
| bus_in | input | 8 | Value seen on the bus |
| epp_wait | input | 1 | Peripheral wait, high closes the cycle |

## Verification
The release property assumes that the peripheral keeps wait high from the moment it raises it until the strobe has risen. It also assumes that, on reads, the peripheral holds its byte stable from before wait rises. The bench peripheral model works this way. On each falling clock edge it raises wait and drives the read byte after a set number of low-strobe cycles. It drops wait only after the strobe is high again. In the timeout cases it holds wait still, and it changes nothing else.

// File: rtl/epp_host_pkg.sv
`timescale 1ns/1ps
package epp_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_GAP    = 3'd4
  } host_st_t;

  localparam int unsigned T_STB = 0;
  localparam int unsigned T_GAP = 1;
  localparam int unsigned T_TO  = 2;
  localparam int unsigned N_TMR = 3;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/epp_host_sync.sv
`timescale 1ns/1ps
module epp_host_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_host_timer.sv
`timescale 1ns/1ps
module epp_host_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/epp_host_master.sv
`timescale 1ns/1ps
module epp_host_master
  import epp_host_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned STROBE_MIN_NS = 80,
  parameter int unsigned SETUP_GAP_NS  = 40,
  parameter int unsigned TIMEOUT_NS    = 10_000_000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          timeout,
  output logic          epp_astb_n,
  output logic          epp_dstb_n,
  output logic          epp_dir,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in,
  input  logic          epp_wait
);

  localparam int unsigned STB_CYC = ns_to_cyc(STROBE_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_CYC = ns_to_cyc(SETUP_GAP_NS, CLK_PERIOD_NS);
  localparam int unsigned TO_CYC  = ns_to_cyc(TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_A   = (STB_CYC > GAP_CYC) ? STB_CYC : GAP_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
  localparam int unsigned TW      = cnt_width(MAX_CYC);

  host_st_t      state, state_nx;
  logic [1:0]    kind_q, kind_nx;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          got_wait, wait_s, wait_hi;
  logic          accept, fin, abort, active_nx, use_dstb_nx;
  logic          astb_q, dstb_q, dir_q, oe_q, done_q, to_q;

  logic [N_TMR-1:0] tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_val [N_TMR];

  epp_host_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (epp_wait),
    .q     (wait_s)
  );

  assign tmr_val[T_STB] = TW'(STB_CYC - 1);
  assign tmr_val[T_GAP] = TW'(GAP_CYC - 1);
  assign tmr_val[T_TO]  = TW'(TO_CYC - 1);

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    epp_host_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load[gi]),
      .load_val (tmr_val[gi]),
      .expired  (tmr_exp[gi])
    );
  end

  assign cmd_ready = (state == ST_IDLE) && !wait_s;
  assign accept    = cmd_valid && cmd_ready;
  assign wait_hi   = got_wait || wait_s;

  always_comb begin
    state_nx = state;
    fin      = 1'b0;
    abort    = 1'b0;
    unique case (state)
      ST_IDLE:   if (accept) state_nx = ST_SETUP;
      ST_SETUP:  state_nx = ST_STROBE;
      ST_STROBE: begin
        if (wait_hi && tmr_exp[T_STB]) begin
          state_nx = ST_HOLD;
        end else if (!wait_hi && tmr_exp[T_TO]) begin
          state_nx = ST_IDLE;
          abort    = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!wait_s) begin
          state_nx = ST_GAP;
          fin      = 1'b1;
        end else if (tmr_exp[T_TO]) begin
          state_nx = ST_IDLE;
          abort    = 1'b1;
        end
      end
      ST_GAP:    if (tmr_exp[T_GAP]) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load        = '0;
    tmr_load[T_STB] = (state == ST_SETUP);
    tmr_load[T_TO]  = (state == ST_SETUP) || (state == ST_STROBE && state_nx == ST_HOLD);
    tmr_load[T_GAP] = (state == ST_HOLD && state_nx == ST_GAP);
  end

  assign kind_nx     = accept ? cmd_kind : kind_q;
  assign use_dstb_nx = kind_nx[1] || kind_nx[0];
  assign active_nx   = (state_nx == ST_SETUP) || (state_nx == ST_STROBE) || (state_nx == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= 2'b00;
      wdata_q  <= '0;
      rdata_q  <= '0;
      got_wait <= 1'b0;
      astb_q   <= 1'b1;
      dstb_q   <= 1'b1;
      dir_q    <= 1'b1;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        kind_q  <= cmd_kind;
        wdata_q <= cmd_wdata;
      end
      if (state == ST_SETUP)                 got_wait <= 1'b0;
      else if (state == ST_STROBE && wait_s) got_wait <= 1'b1;
      if (state == ST_STROBE && wait_s && !got_wait && kind_q[1])
        rdata_q <= bus_in;
      astb_q <= !((state_nx == ST_STROBE) && !use_dstb_nx);
      dstb_q <= !((state_nx == ST_STROBE) && use_dstb_nx);
      dir_q  <= !(active_nx && !kind_nx[1]);
      oe_q   <= active_nx && !kind_nx[1];
      done_q <= fin;
      to_q   <= abort;
    end
  end

  assign epp_astb_n = astb_q;
  assign epp_dstb_n = dstb_q;
  assign epp_dir    = dir_q;
  assign bus_oe     = oe_q;
  assign bus_out    = wdata_q;
  assign done       = done_q;
  assign done_rdata = rdata_q;
  assign timeout    = to_q;

endmodule

// File: rtl/epp_host_master_chk.sv
`timescale 1ns/1ps
module epp_host_master_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          done,
  input logic          timeout,
  input logic          epp_astb_n,
  input logic          epp_dstb_n,
  input logic          epp_dir,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic          epp_wait
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (epp_astb_n && epp_dstb_n && epp_dir && !bus_oe && !done && !timeout));

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (epp_astb_n && epp_dstb_n && epp_dir && !bus_oe));

  p_addr_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !epp_astb_n |-> (!epp_dir && bus_oe));

  p_data_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!epp_dstb_n && !epp_dir) |-> bus_oe);

  p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!epp_dstb_n && epp_dir) |-> !bus_oe);

  p_release_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(epp_astb_n) || $rose(epp_dstb_n)) |-> ($past(epp_wait) || timeout));

  p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (epp_astb_n && epp_dstb_n && epp_dir && !bus_oe));

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout}));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_astb_n || epp_dstb_n));

  p_stable_in_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((!epp_astb_n || !epp_dstb_n) && $past(!epp_astb_n || !epp_dstb_n))
      |-> ($stable(epp_dir) && $stable(bus_oe) && $stable(bus_out)));

endmodule

bind epp_host_master epp_host_master_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .done       (done),
  .timeout    (timeout),
  .epp_astb_n (epp_astb_n),
  .epp_dstb_n (epp_dstb_n),
  .epp_dir    (epp_dir),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .epp_wait   (epp_wait)
);

// File: tb/epp_host_master_tb.sv
`timescale 1ns/1ps
module epp_host_master_tb;
  localparam int TO_NS   = 2000;
  localparam int STB_CYC = 16;
  localparam int GAP_CYC = 8;
  localparam int TO_CYC  = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic cmd_ready, done, timeout, epp_astb_n, epp_dstb_n, epp_dir, bus_oe;
  logic [7:0] done_rdata, bus_out;
  logic [7:0] bus_in = 8'h00;
  logic per_wait = 1'b0, force_wait = 1'b0;
  logic epp_wait;
  assign epp_wait = per_wait | force_wait;

  always #2.5 clk = ~clk;

  epp_host_master #(.CLK_PERIOD_NS(5), .STROBE_MIN_NS(80), .SETUP_GAP_NS(40),
                    .TIMEOUT_NS(TO_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_wdata(cmd_wdata), .done(done), .done_rdata(done_rdata),
    .timeout(timeout), .epp_astb_n(epp_astb_n), .epp_dstb_n(epp_dstb_n),
    .epp_dir(epp_dir), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .epp_wait(epp_wait));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // peripheral model
  int rise_dly = 0, fall_dly = 0;
  bit never_rise = 0, never_fall = 0;
  logic [7:0] rd_byte = 8'h00;
  int cyc = 0, low_cnt = 0, hi_cnt = 0, last_low = 0, wait_fall_cyc = 0, last_gap = 0;
  bit cap_astb, cap_dstb, cap_dir, cap_oe;
  logic [7:0] cap_bus;
  bit stab_err = 0, both_err = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      per_wait = 1'b0; low_cnt = 0; hi_cnt = 0;
    end else if (!epp_astb_n || !epp_dstb_n) begin
      low_cnt++;
      if (low_cnt == 1) begin
        cap_astb = !epp_astb_n; cap_dstb = !epp_dstb_n; cap_dir = epp_dir;
        cap_oe = bus_oe; cap_bus = bus_out; last_gap = cyc - wait_fall_cyc;
      end else if (epp_dir !== cap_dir || bus_oe !== cap_oe || bus_out !== cap_bus) begin
        stab_err = 1;
      end
      if (!epp_astb_n && !epp_dstb_n) both_err = 1;
      if (!never_rise && low_cnt > rise_dly && !per_wait) begin
        per_wait = 1'b1; bus_in = rd_byte;
      end
    end else begin
      if (low_cnt != 0) begin last_low = low_cnt; low_cnt = 0; hi_cnt = 0; end
      if (per_wait && !never_fall) begin
        hi_cnt++;
        if (hi_cnt > fall_dly) begin per_wait = 1'b0; wait_fall_cyc = cyc; bus_in = 8'h00; end
      end
    end
  end

  // drive one command, wait for done or timeout
  task automatic run_cmd(input logic [1:0] kind, input logic [7:0] wd,
                         output bit got_done, output bit got_to,
                         output logic [7:0] rdata, output int elapsed);
    got_done = 0; got_to = 0; rdata = 8'h00; elapsed = 0;
    cmd_kind = kind; cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      elapsed++;
      if (done || timeout) break;
      @(negedge clk);
    end
    got_done = done; got_to = timeout; rdata = done_rdata;
    chk(!(done && timeout), "R10", "done and timeout together", {done, timeout}, 2'b00);
    if (done) chk(epp_wait == 1'b0, "R7", "done while wait high", epp_wait, 0);
    if (got_to) begin
      chk(epp_astb_n && epp_dstb_n && epp_dir && !bus_oe, "R8",
          "outputs not idle at timeout", {epp_astb_n, epp_dstb_n, epp_dir, bus_oe}, 4'b1110);
    end
    @(negedge clk);
    chk(!done && !timeout, "R10", "pulse wider than one cycle", {done, timeout}, 2'b00);
  endtask

  task automatic t_reset();
    chk(epp_astb_n && epp_dstb_n && epp_dir && !bus_oe && !done && !timeout, "R1",
        "reset outputs", {epp_astb_n, epp_dstb_n, epp_dir, bus_oe, done, timeout}, 6'b111000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R2", "ready after reset", cmd_ready, 1);
    chk(epp_astb_n && epp_dstb_n, "R1", "strobes after reset", {epp_astb_n, epp_dstb_n}, 2'b11);
  endtask

  task automatic t_addr_write();
    bit d, t; logic [7:0] r; int e;
    rise_dly = 0; fall_dly = 1; stab_err = 0;
    run_cmd(2'b00, 8'hA5, d, t, r, e);
    chk(d && !t, "R3", "address write done", {d, t}, 2'b10);
    chk(cap_astb && !cap_dstb, "R3", "strobe used", {cap_astb, cap_dstb}, 2'b10);
    chk(!cap_dir && cap_oe, "R3", "dir/oe during strobe", {cap_dir, cap_oe}, 2'b01);
    chk(cap_bus == 8'hA5, "R3", "bus byte", cap_bus, 8'hA5);
    chk(last_low >= STB_CYC, "R6", "minimum strobe width", last_low, STB_CYC);
    chk(!stab_err, "R11", "bus/dir moved in strobe", stab_err, 0);
  endtask

  task automatic t_data_write_slow();
    bit d, t; logic [7:0] r; int e;
    rise_dly = 40; fall_dly = 3; stab_err = 0;
    run_cmd(2'b01, 8'h3C, d, t, r, e);
    chk(d && !t, "R4", "data write done", {d, t}, 2'b10);
    chk(!cap_astb && cap_dstb, "R4", "strobe used", {cap_astb, cap_dstb}, 2'b01);
    chk(!cap_dir && cap_oe && cap_bus == 8'h3C, "R4", "drive during strobe",
        {cap_dir, cap_oe, cap_bus}, {2'b01, 8'h3C});
    chk(last_low > 40, "R6", "strobe held until wait", last_low, 41);
    chk(!stab_err, "R11", "bus/dir moved in strobe", stab_err, 0);
  endtask

  task automatic t_data_read();
    bit d, t; logic [7:0] r; int e;
    rise_dly = 5; fall_dly = 2; rd_byte = 8'h96;
    run_cmd(2'b10, 8'h00, d, t, r, e);
    chk(d && !t, "R5", "read done", {d, t}, 2'b10);
    chk(cap_dstb && cap_dir && !cap_oe, "R5", "read strobe/dir/oe",
        {cap_dstb, cap_dir, cap_oe}, 3'b110);
    chk(r == 8'h96, "R5", "read byte", r, 8'h96);
    rd_byte = 8'h5E;
    run_cmd(2'b11, 8'h00, d, t, r, e);
    chk(d && r == 8'h5E, "R5", "read via kind 11", r, 8'h5E);
  endtask

  task automatic t_back_to_back();
    bit d, t; logic [7:0] r; int e;
    rise_dly = 0; fall_dly = 0;
    run_cmd(2'b01, 8'h11, d, t, r, e);
    run_cmd(2'b00, 8'h22, d, t, r, e);
    chk(last_gap >= GAP_CYC, "R7", "gap wait-low to next strobe", last_gap, GAP_CYC);
    chk(!both_err, "R11", "both strobes low", both_err, 0);
  endtask

  task automatic t_busy_idle();
    bit d, t; logic [7:0] r; int e;
    bit moved = 0;
    force_wait = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b0, "R2", "ready while wait high", cmd_ready, 0);
    cmd_kind = 2'b01; cmd_wdata = 8'h77; cmd_valid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!epp_astb_n || !epp_dstb_n) moved = 1;
    end
    chk(!moved, "R2", "strobe under back-pressure", moved, 0);
    force_wait = 1'b0;
    run_cmd(2'b01, 8'h77, d, t, r, e);
    chk(d && cap_bus == 8'h77, "R2", "held command taken", cap_bus, 8'h77);
  endtask

  task automatic t_timeout_rise();
    bit d, t; logic [7:0] r; int e;
    never_rise = 1;
    run_cmd(2'b00, 8'h42, d, t, r, e);
    chk(t && !d, "R8", "timeout without wait rise", {d, t}, 2'b01);
    chk(e >= TO_CYC && e <= TO_CYC + 8, "R8", "timeout latency", e, TO_CYC);
    never_rise = 0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R8", "ready after timeout", cmd_ready, 1);
  endtask

  task automatic t_timeout_fall();
    bit d, t; logic [7:0] r; int e;
    rise_dly = 0; never_fall = 1;
    run_cmd(2'b01, 8'h99, d, t, r, e);
    chk(t && !d, "R9", "timeout without wait fall", {d, t}, 2'b01);
    chk(cmd_ready == 1'b0, "R9", "ready while wait stuck high", cmd_ready, 0);
    never_fall = 0; fall_dly = 0;
    repeat (6) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready after wait falls", cmd_ready, 1);
    run_cmd(2'b00, 8'h0F, d, t, r, e);
    chk(d && cap_bus == 8'h0F, "R9", "recovery cycle", cap_bus, 8'h0F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_addr_write();
    t_data_write_slow();
    t_data_read();
    t_back_to_back();
    t_busy_idle();
    t_timeout_rise();
    t_timeout_fall();
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule